// File: doc/BRIEF.md
# Configurable I/O Cell Bank

This block is a bank of sixteen I/O cells. Each cell serves one bidirectional pad, which is modelled as three separate signals: the value read from the pad, the value driven onto it, and the driver enable. Configuration inputs set each cell on its own. They select the cell's mode, which of the two I/O clocks it uses, whether its output is inverted, and which of sixteen internal logic lines it drives out. A single output-enable input is shared by the whole bank, and it controls the cells set to bidirectional mode.

In the input direction, a cell hands the pad value to the core in one of three ways: straight through, captured on a rising edge of its I/O clock, or through a latch that is transparent while that clock is high. All sequential state runs on one core clock `clk`. The two I/O clock inputs are sampled as levels in that domain, and a rising edge is taken to be a clock edge at which the selected line is high after being low at the previous edge. Pads are level signals with no flow control, so the block has no valid/ready handshakes and no back-pressure. Every data path moves one value per cycle, with no stall.

Top module: `iocb_bank`

## Requirements
- R1: Mode code 0 (bits [3i+2:3i] of `cfg_mode` for cell i) is a direct input: `core_in[i]` equals `pad_in[i]` in the same cycle, and `pad_oe[i]` is 0.
- R2: Mode code 1 is a registered input. At a `clk` edge where the cell's selected I/O clock is sampled high, after being sampled low at the previous edge, the stored bit takes `pad_in[i]`, and `core_in[i]` shows it from then on. At every other edge the stored bit holds. `pad_oe[i]` is 0.
- R3: Mode code 2 is a latched input. While the selected I/O clock is high, `core_in[i]` follows `pad_in[i]` combinationally. While it is low, `core_in[i]` holds the value sampled at the last `clk` edge where the clock was high. `pad_oe[i]` is 0.
- R4: Bit i of `cfg_clksel` selects the I/O clock for cell i: 0 selects `ioclk[0]` and 1 selects `ioclk[1]`.
- R5: Mode code 3 is output only: `pad_oe[i]` is 1 and `core_in[i]` is 0.
- R6: Mode code 4 is bidirectional: `pad_oe[i]` equals `oe_shared`, and `core_in[i]` equals `pad_in[i]`.
- R7: Codes 5, 6 and 7 are reserved and behave exactly as code 0.
- R8: In every mode, `pad_out[i]` equals `logic_out[s] XOR cfg_inv[i]`. Here s is the 4-bit field `cfg_src[4i+3:4i]`, so inversion is applied after the line is selected.
- R9: A high `rst` at a `clk` edge clears every stored input bit to 0.
- R10: Each cell's behaviour depends only on its own configuration fields, with `ioclk`, `oe_shared` and `logic_out` as the only shared inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| ioclk | input | 2 | I/O clock levels, sampled on `clk` |
| oe_shared | input | 1 | Bank-wide output enable for bidirectional cells |
| logic_out | input | 16 | Internal logic lines available to drive the pads |
| cfg_mode | input | 48 | 3-bit mode code per cell |
| cfg_clksel | input | 16 | I/O clock select per cell |
| cfg_inv | input | 16 | Output inversion per cell |
| cfg_src | input | 64 | 4-bit source line select per cell |
| pad_in | input | 16 | Value read from each pad |
| pad_out | output | 16 | Value driven onto each pad |
| pad_oe | output | 16 | Driver enable for each pad |
| core_in | output | 16 | Input value presented to the core |

## Verification
The assertions check on every cycle that the driver enable matches each cell's mode and the shared enable, and that an output-mode cell returns 0 to the core. They also check that a bidirectional cell passes its pad through, that a registered cell holds between clock rises, that a latched cell holds while its clock is low, and that a registered cell reads 0 after reset. Only the bench's scenarios can show that the correct value is captured: the pad value present at the rising edge or latch closing, on the cell's chosen clock and not the other one. The same holds for the exact line and polarity reaching each pad across all sixteen source selections. The mixed-mode sweeps show that cells configured differently at the same time do not interfere with each other.

// File: rtl/iocb_pkg.sv
package iocb_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_COMB  = 3'd0,
    MODE_REG   = 3'd1,
    MODE_LATCH = 3'd2,
    MODE_OUT   = 3'd3,
    MODE_BIDIR = 3'd4
  } iomode_e;

  typedef struct packed {
    logic drv_always;
    logic drv_shared;
    logic use_reg;
    logic use_latch;
    logic block_in;
  } cell_ctl_t;
endpackage

// File: rtl/iocb_mode_dec.sv
module iocb_mode_dec
  import iocb_pkg::*;
(
  input  logic [MODE_W-1:0] mode_code,
  output cell_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    case (mode_code)
      MODE_REG:   ctl.use_reg    = 1'b1;
      MODE_LATCH: ctl.use_latch  = 1'b1;
      MODE_OUT: begin
        ctl.drv_always = 1'b1;
        ctl.block_in   = 1'b1;
      end
      MODE_BIDIR: ctl.drv_shared = 1'b1;
      default:    ctl = '0;
    endcase
  end
endmodule

// File: rtl/iocb_out_path.sv
module iocb_out_path #(
  parameter int NSRC  = 16,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  logic_out,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             invert,
  output logic             pad_val
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_sel == SRC_W'(k)) picked = logic_out[k];
    end
    pad_val = picked ^ invert;
  end
endmodule

// File: rtl/iocb_in_path.sv
module iocb_in_path
  import iocb_pkg::*;
#(
  parameter int NIOCLK = 2,
  parameter int CSEL_W = (NIOCLK > 1) ? $clog2(NIOCLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIOCLK-1:0] ioclk_lvl,
  input  logic [NIOCLK-1:0] ioclk_rise,
  input  logic [CSEL_W-1:0] clk_sel,
  input  cell_ctl_t         ctl,
  input  logic              pad_bit,
  output logic              core_bit
);
  logic sel_lvl;
  logic sel_rise;
  logic stored;

  always_comb begin
    sel_lvl  = 1'b0;
    sel_rise = 1'b0;
    for (int k = 0; k < NIOCLK; k++) begin
      if (clk_sel == CSEL_W'(k)) begin
        sel_lvl  = ioclk_lvl[k];
        sel_rise = ioclk_rise[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= 1'b0;
    end else if ((ctl.use_reg && sel_rise) || (ctl.use_latch && sel_lvl)) begin
      stored <= pad_bit;
    end
  end

  always_comb begin
    if (ctl.block_in)                 core_bit = 1'b0;
    else if (ctl.use_latch && sel_lvl) core_bit = pad_bit;
    else if (ctl.use_reg || ctl.use_latch) core_bit = stored;
    else                              core_bit = pad_bit;
  end
endmodule

// File: rtl/iocb_bank.sv
module iocb_bank
  import iocb_pkg::*;
#(
  parameter int NCELL  = 16,
  parameter int NSRC   = 16,
  parameter int NIOCLK = 2,
  localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CSEL_W = (NIOCLK > 1) ? $clog2(NIOCLK) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NIOCLK-1:0]         ioclk,
  input  logic                      oe_shared,
  input  logic [NSRC-1:0]           logic_out,
  input  logic [NCELL*MODE_W-1:0]   cfg_mode,
  input  logic [NCELL*CSEL_W-1:0]   cfg_clksel,
  input  logic [NCELL-1:0]          cfg_inv,
  input  logic [NCELL*SRC_W-1:0]    cfg_src,
  input  logic [NCELL-1:0]          pad_in,
  output logic [NCELL-1:0]          pad_out,
  output logic [NCELL-1:0]          pad_oe,
  output logic [NCELL-1:0]          core_in
);
  logic [NIOCLK-1:0] ioclk_q;
  logic [NIOCLK-1:0] ioclk_rise;

  // Previous level tracks the line even during reset so edge detection
  // after reset reflects the real line history.
  always_ff @(posedge clk) begin
    ioclk_q <= ioclk;
  end

  assign ioclk_rise = ioclk & ~ioclk_q;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cell_ctl_t ctl;

    iocb_mode_dec u_dec (
      .mode_code (cfg_mode[i*MODE_W +: MODE_W]),
      .ctl       (ctl)
    );

    iocb_out_path #(.NSRC(NSRC), .SRC_W(SRC_W)) u_out (
      .logic_out (logic_out),
      .src_sel   (cfg_src[i*SRC_W +: SRC_W]),
      .invert    (cfg_inv[i]),
      .pad_val   (pad_out[i])
    );

    iocb_in_path #(.NIOCLK(NIOCLK), .CSEL_W(CSEL_W)) u_in (
      .clk        (clk),
      .rst        (rst),
      .ioclk_lvl  (ioclk),
      .ioclk_rise (ioclk_rise),
      .clk_sel    (cfg_clksel[i*CSEL_W +: CSEL_W]),
      .ctl        (ctl),
      .pad_bit    (pad_in[i]),
      .core_bit   (core_in[i])
    );

    assign pad_oe[i] = ctl.drv_always | (ctl.drv_shared & oe_shared);
  end
endmodule

// File: rtl/iocb_bank_chk.sv
module iocb_bank_chk
  import iocb_pkg::*;
#(
  parameter int NCELL  = 16,
  parameter int NSRC   = 16,
  parameter int NIOCLK = 2,
  localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CSEL_W = (NIOCLK > 1) ? $clog2(NIOCLK) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NIOCLK-1:0]       ioclk,
  input logic                    oe_shared,
  input logic [NSRC-1:0]         logic_out,
  input logic [NCELL*MODE_W-1:0] cfg_mode,
  input logic [NCELL*CSEL_W-1:0] cfg_clksel,
  input logic [NCELL-1:0]        cfg_inv,
  input logic [NCELL*SRC_W-1:0]  cfg_src,
  input logic [NCELL-1:0]        pad_in,
  input logic [NCELL-1:0]        pad_out,
  input logic [NCELL-1:0]        pad_oe,
  input logic [NCELL-1:0]        core_in
);
  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    logic [MODE_W-1:0] md;
    logic [CSEL_W-1:0] cs;
    logic              sel_clk;

    assign md = cfg_mode[i*MODE_W +: MODE_W];
    assign cs = cfg_clksel[i*CSEL_W +: CSEL_W];
    always_comb begin
      sel_clk = 1'b0;
      for (int k = 0; k < NIOCLK; k++) if (cs == CSEL_W'(k)) sel_clk = ioclk[k];
    end

    // R1 R2 R3 R7
    input_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
      (md <= 3'd2 || md >= 3'd5) |-> !pad_oe[i]);

    // R5
    out_mode_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 3'd3) |-> (pad_oe[i] && !core_in[i]));

    // R6
    bidir_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 3'd4) |-> (pad_oe[i] == oe_shared && core_in[i] == pad_in[i]));

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 3'd1 && !$rose(sel_clk)) |=>
        (!$stable(md) || !$stable(cs) || $stable(core_in[i])));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 3'd2 && !sel_clk) |=>
        (!$stable(md) || !$stable(cs) || sel_clk || $stable(core_in[i])));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (md != 3'd1 || !core_in[i]));
  end
endmodule

bind iocb_bank iocb_bank_chk #(.NCELL(NCELL), .NSRC(NSRC), .NIOCLK(NIOCLK)) u_chk (.*);

// File: tb/iocb_bank_bench.sv
module iocb_bank_bench;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    ioclk;
  logic          oe_shared;
  logic [15:0]   logic_out;
  logic [47:0]   cfg_mode;
  logic [15:0]   cfg_clksel;
  logic [15:0]   cfg_inv;
  logic [63:0]   cfg_src;
  logic [15:0]   pad_in;
  logic [15:0]   pad_out;
  logic [15:0]   pad_oe;
  logic [15:0]   core_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  iocb_bank u_iocb_bank (
    .clk(clk), .rst(rst), .ioclk(ioclk), .oe_shared(oe_shared),
    .logic_out(logic_out), .cfg_mode(cfg_mode), .cfg_clksel(cfg_clksel),
    .cfg_inv(cfg_inv), .cfg_src(cfg_src), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic all_mode(input logic [2:0] m);
    for (int i = 0; i < N; i++) cfg_mode[i*3 +: 3] = m;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int n);
    case (n % 4)
      0: pat = 16'h0000;
      1: pat = 16'hFFFF;
      2: pat = 16'h5A5A;
      default: pat = 16'h3C96;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] even_m, p1, p2, p3, exp_v;
    rst = 1'b1; ioclk = 2'b00; oe_shared = 1'b0; logic_out = '0;
    cfg_mode = '0; cfg_clksel = '0; cfg_inv = '0; cfg_src = '0; pad_in = '0;
    even_m = 16'h5555;
    tick();
    all_mode(3'd1);
    tick(); tick();
    // R9 reset state
    chk(core_in == 16'h0, "R9 reset core_in", core_in, 0);
    chk(pad_oe == 16'h0, "R2 reset pad_oe", pad_oe, 0);
    rst = 1'b0;

    // R8 R5 output path sweep over every source select and polarity
    all_mode(3'd3);
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 2; v++) begin
        logic_out = 16'h9C35 ^ 16'(s * 16'h0F0F);
        for (int i = 0; i < N; i++) begin
          cfg_src[i*4 +: 4] = 4'((s + i) % 16);
          cfg_inv[i] = v[0] ^ i[1];
        end
        pad_in = pat(s + v);
        #1;
        for (int i = 0; i < N; i++) begin
          exp_v[0] = logic_out[(s + i) % 16] ^ v[0] ^ i[1];
          chk(pad_out[i] == exp_v[0], "R8 pad_out", pad_out[i], exp_v[0]);
        end
        chk(pad_oe == 16'hFFFF, "R5 oe", pad_oe, 16'hFFFF);
        chk(core_in == 16'h0, "R5 core_in", core_in, 0);
        tick();
      end
    end

    // R1 R5 R6 R7 R10 mixed modes across cells
    do_reset();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < N; i++) cfg_mode[i*3 +: 3] = 3'((i + k) % 8);
      for (int o = 0; o < 2; o++) begin
        for (int p = 0; p < 4; p++) begin
          oe_shared = o[0];
          pad_in = pat(p + k);
          #1;
          for (int i = 0; i < N; i++) begin
            int m;
            logic eo, ec;
            m = (i + k) % 8;
            eo = (m == 3) ? 1'b1 : (m == 4) ? o[0] : 1'b0;
            ec = (m == 3) ? 1'b0 : (m == 1 || m == 2) ? 1'b0 : pad_in[i];
            chk(pad_oe[i] == eo, "R1/R5/R6/R7 oe R10", pad_oe[i], eo);
            chk(core_in[i] == ec, "R1/R5/R6/R7 core R10", core_in[i], ec);
          end
          tick();
        end
      end
    end

    // R2 R4 registered capture on the selected clock
    oe_shared = 1'b0;
    all_mode(3'd1);
    for (int i = 0; i < N; i++) cfg_clksel[i] = i[0];
    do_reset();
    p1 = 16'hC3A5; p2 = 16'h7E18; p3 = 16'h0FF0;
    pad_in = p1; ioclk = 2'b00; tick();
    chk(core_in == 16'h0, "R2 hold without rise", core_in, 0);
    ioclk = 2'b01; tick();
    exp_v = p1 & even_m;
    chk(core_in == exp_v, "R2 R4 capture ioclk0", core_in, exp_v);
    pad_in = p2; tick();
    chk(core_in == exp_v, "R2 no capture while high", core_in, exp_v);
    ioclk = 2'b11; tick();
    exp_v = (p1 & even_m) | (p2 & ~even_m);
    chk(core_in == exp_v, "R2 R4 capture ioclk1", core_in, exp_v);
    pad_in = p3; ioclk = 2'b00; tick();
    chk(core_in == exp_v, "R2 hold after fall", core_in, exp_v);
    ioclk = 2'b10; tick();
    exp_v = (p1 & even_m) | (p3 & ~even_m);
    chk(core_in == exp_v, "R4 only ioclk1 cells", core_in, exp_v);

    // R3 R4 latched input
    ioclk = 2'b00;
    all_mode(3'd2);
    do_reset();
    pad_in = p1; ioclk = 2'b01; #1;
    exp_v = p1 & even_m;
    chk(core_in == exp_v, "R3 R4 transparent", core_in, exp_v);
    tick();
    pad_in = p2; ioclk = 2'b00; #1;
    chk(core_in == exp_v, "R3 hold low", core_in, exp_v);
    tick();
    chk(core_in == exp_v, "R3 hold next cycle", core_in, exp_v);
    pad_in = p3; ioclk = 2'b10; #1;
    exp_v = (p1 & even_m) | (p3 & ~even_m);
    chk(core_in == exp_v, "R3 R4 ioclk1 transparent", core_in, exp_v);
    tick();
    ioclk = 2'b00; pad_in = 16'h0; #1;
    chk(core_in == exp_v, "R3 hold both", core_in, exp_v);

    // R9 reset clears latched state
    rst = 1'b1; tick(); rst = 1'b0; #1;
    chk(core_in == 16'h0, "R9 reset clears latch", core_in, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule